// File: doc/BRIEF.md
# MAC Frame Acceptance Filter

This block sits beside a receiver and watches the octets of an IEEE 802.15.4 MAC frame as they come in. From the header it takes the frame type and the destination addressing mode, then the destination PAN identifier and the destination address (16-bit short or 64-bit extended). It checks these against the node's own identity. When the frame ends, the receiver reports whether the FCS was good. The block then makes one accept/reject decision. That decision gates the frame-received and good-CRC interrupt status.

With filtering switched off, every frame whose FCS is good is accepted. With filtering on, a frame must also meet three conditions. Its type must be allowed by a per-type enable. Its header must be complete. Its destination must be addressed to this node or be a broadcast.

Top module: `mac_frame_filter`

## Requirements
- R1: After reset, `dec_valid` and `accept` are both 0.
- R2: A cycle with `frm_start` high makes `dec_valid` and `accept` 0 from the next cycle on. If `frm_end` is high in the same cycle, `frm_start` wins.
- R3: A `frm_end` inside a frame sets `dec_valid` to 1 in the next cycle. `dec_valid` and `accept` then hold until the next `frm_start`.
- R4: If `fcs_ok` is 0 in the `frm_end` cycle, `accept` is 0, whatever the filter settings.
- R5: With `filt_en` at 0, `accept` equals `fcs_ok` as sampled with `frm_end`. This holds for any frame length and content.
- R6: The frame type is bits 2:0 of octet 0. Types 0 to 5 are checked against `type_allow` bits 0 to 5 (beacon, data, ack, command, type 4, type 5). Types 6 and 7 share bit 6. When filtering is on, a frame whose allow bit is 0 is rejected.
- R7: The destination addressing mode is bits 3:2 of octet 1: 0 none, 1 reserved, 2 short, 3 extended. With mode 0 the address check passes. With mode 1 the frame is rejected. Octets 3-4 carry the destination PAN and the destination address follows from octet 5. All multi-octet fields arrive least significant octet first.
- R8: The destination PAN must equal `own_pan` or 0xFFFF.
- R9: A short destination address must equal `own_short` or 0xFFFF.
- R10: An extended destination address must equal `own_ext` exactly. There is no broadcast value for it.
- R11: With filtering on, a frame is rejected if it ends before its header is complete. Mode 0 needs 3 octets, mode 2 needs 7 and mode 3 needs 13.
- R12: Octets and `frm_end` that arrive outside a frame (after reset or after `frm_end`, before `frm_start`) have no effect. The same holds for an octet in the `frm_start` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_start | input | 1 | Start-of-frame pulse, sent before the first octet |
| frm_end | input | 1 | End-of-frame pulse, sent after the last octet |
| fcs_ok | input | 1 | FCS check result, sampled with `frm_end` |
| oct_valid | input | 1 | Octet strobe |
| oct_data | input | 8 | Received octet |
| filt_en | input | 1 | Turns on type and address filtering |
| type_allow | input | 7 | Per-frame-type acceptance enables |
| own_pan | input | 16 | Local PAN identifier |
| own_short | input | 16 | Local short address |
| own_ext | input | 64 | Local extended address |
| dec_valid | output | 1 | Decision is available |
| accept | output | 1 | Frame accepted; gates the received and good-CRC status |

## Verification
Internal state errors show up at the ports as a wrong value of `accept` one cycle after `frm_end`. A misread frame type, a field byte stored at the wrong octet index, a stale match flag from an earlier frame, or a counter that advanced outside a frame all appear this way. A decision register that fails to hold or fails to clear shows as `dec_valid` or `accept` changing between the decision and the next `frm_start`, or staying set one cycle after a start. The bench compares a behavioural model against both outputs on every clock, so each such fault is seen within one cycle of its first effect.

// File: rtl/mff_pkg.sv
package mff_pkg;

   typedef enum logic [1:0] {
      DM_NONE  = 2'd0,
      DM_RSVD  = 2'd1,
      DM_SHORT = 2'd2,
      DM_EXT   = 2'd3
   } dst_mode_e;

   localparam int OCT_W      = 8;
   localparam int FTYPE_W    = 3;
   localparam int N_ALLOW    = 7;
   localparam int FC_SEQ_LEN = 3;   // frame control (2) + sequence number (1)

   // Map a 3-bit frame type onto its allow-bit index; 6 and 7 share one bit.
   function automatic logic [2:0] allow_index(input logic [FTYPE_W-1:0] t);
      return (t > 3'd5) ? 3'd6 : t;
   endfunction

endpackage

// File: rtl/mff_hdr_parse.sv
module mff_hdr_parse
   import mff_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sof,
   input  logic                eof,
   input  logic                oct_v,
   input  logic [OCT_W-1:0]    octet,
   output logic                take,
   output logic                eof_take,
   output logic [CNT_W-1:0]    cnt,
   output logic [FTYPE_W-1:0]  ftype,
   output dst_mode_e           dmode
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic in_frame;

   assign take     = oct_v & in_frame & ~sof;
   assign eof_take = eof & in_frame & ~sof;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         cnt      <= '0;
         ftype    <= '0;
         dmode    <= DM_NONE;
      end else if (sof) begin
         in_frame <= 1'b1;
         cnt      <= '0;
         ftype    <= '0;
         dmode    <= DM_NONE;
      end else begin
         if (eof) in_frame <= 1'b0;
         if (take) begin
            if (cnt == '0)              ftype <= octet[2:0];
            if (cnt == CNT_W'(1))       dmode <= dst_mode_e'(octet[3:2]);
            if (cnt != CNT_MAX)         cnt   <= cnt + 1'b1;
         end
      end
   end

   // R12: with no frame open, the octet count stays put
   a_r12_no_count_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame && !sof) |=> $stable(cnt));

   // R2: a frame start rewinds the count
   a_r2_count_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (cnt == '0));

endmodule

// File: rtl/mff_addr_match.sv
module mff_addr_match
   import mff_pkg::*;
#(
   parameter int PAN_W      = 16,
   parameter int SADDR_W    = 16,
   parameter int EADDR_W    = 64,
   parameter int CNT_W      = 4,
   parameter bit STREAM_CMP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sof,
   input  logic                take,
   input  logic [CNT_W-1:0]    idx,
   input  logic [OCT_W-1:0]    octet,
   input  logic [PAN_W-1:0]    own_pan,
   input  logic [SADDR_W-1:0]  own_short,
   input  logic [EADDR_W-1:0]  own_ext,
   output logic                pan_ok,
   output logic                sa_ok,
   output logic                ea_ok
);

   localparam int PAN_B   = PAN_W / OCT_W;
   localparam int SA_B    = SADDR_W / OCT_W;
   localparam int EA_B    = EADDR_W / OCT_W;
   localparam int PAN_OFS = FC_SEQ_LEN;
   localparam int ADR_OFS = PAN_OFS + PAN_B;

   localparam logic [CNT_W-1:0] PAN_LO = CNT_W'(PAN_OFS);
   localparam logic [CNT_W-1:0] PAN_HI = CNT_W'(PAN_OFS + PAN_B);
   localparam logic [CNT_W-1:0] ADR_LO = CNT_W'(ADR_OFS);
   localparam logic [CNT_W-1:0] SA_HI  = CNT_W'(ADR_OFS + SA_B);
   localparam logic [CNT_W-1:0] EA_HI  = CNT_W'(ADR_OFS + EA_B);

   if (STREAM_CMP) begin : g_stream
      // Running per-field match flags, updated as each octet arrives.
      logic             pan_eq, pan_bc, sa_eq, sa_bc, ea_eq;
      logic [CNT_W-1:0] pan_pos, adr_pos;
      logic [OCT_W-1:0] pan_byte, sa_byte, ea_byte;
      logic             in_pan, in_sa, in_ea;

      assign pan_pos  = idx - PAN_LO;
      assign adr_pos  = idx - ADR_LO;
      assign pan_byte = OCT_W'(own_pan   >> {pan_pos, 3'b000});
      assign sa_byte  = OCT_W'(own_short >> {adr_pos, 3'b000});
      assign ea_byte  = OCT_W'(own_ext   >> {adr_pos, 3'b000});
      assign in_pan   = take && (idx >= PAN_LO) && (idx < PAN_HI);
      assign in_sa    = take && (idx >= ADR_LO) && (idx < SA_HI);
      assign in_ea    = take && (idx >= ADR_LO) && (idx < EA_HI);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pan_eq <= 1'b0;
            pan_bc <= 1'b0;
            sa_eq  <= 1'b0;
            sa_bc  <= 1'b0;
            ea_eq  <= 1'b0;
         end else if (sof) begin
            pan_eq <= 1'b0;
            pan_bc <= 1'b0;
            sa_eq  <= 1'b0;
            sa_bc  <= 1'b0;
            ea_eq  <= 1'b0;
         end else begin
            if (in_pan) begin
               pan_eq <= ((idx == PAN_LO) | pan_eq) & (octet == pan_byte);
               pan_bc <= ((idx == PAN_LO) | pan_bc) & (&octet);
            end
            if (in_sa) begin
               sa_eq <= ((idx == ADR_LO) | sa_eq) & (octet == sa_byte);
               sa_bc <= ((idx == ADR_LO) | sa_bc) & (&octet);
            end
            if (in_ea) begin
               ea_eq <= ((idx == ADR_LO) | ea_eq) & (octet == ea_byte);
            end
         end
      end

      assign pan_ok = pan_eq | pan_bc;
      assign sa_ok  = sa_eq | sa_bc;
      assign ea_ok  = ea_eq;

   end else begin : g_capture
      // Store the destination fields whole; compare once the frame ends.
      logic [PAN_W-1:0]   cap_pan;
      logic [EADDR_W-1:0] cap_adr;

      for (genvar b = 0; b < PAN_B; b++) begin : g_pan_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        cap_pan[b*OCT_W +: OCT_W] <= '0;
            else if (sof)                                      cap_pan[b*OCT_W +: OCT_W] <= '0;
            else if (take && (idx == CNT_W'(PAN_OFS + b)))     cap_pan[b*OCT_W +: OCT_W] <= octet;
         end
      end

      for (genvar b = 0; b < EA_B; b++) begin : g_adr_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        cap_adr[b*OCT_W +: OCT_W] <= '0;
            else if (sof)                                      cap_adr[b*OCT_W +: OCT_W] <= '0;
            else if (take && (idx == CNT_W'(ADR_OFS + b)))     cap_adr[b*OCT_W +: OCT_W] <= octet;
         end
      end

      assign pan_ok = (cap_pan == own_pan) || (&cap_pan);
      assign sa_ok  = (cap_adr[SADDR_W-1:0] == own_short) || (&cap_adr[SADDR_W-1:0]);
      assign ea_ok  = (cap_adr == own_ext);
   end

   // R8: a wrong, non-broadcast first PAN octet kills the PAN match
   a_r8_pan_first_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (take && idx == PAN_LO && octet != own_pan[7:0] && octet != 8'hFF) |=> !pan_ok);

   // R9: a wrong, non-broadcast first short-address octet kills the short match
   a_r9_short_first_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (take && idx == ADR_LO && octet != own_short[7:0] && octet != 8'hFF) |=> !sa_ok);

   // R10: extended match has no broadcast; any wrong first octet kills it
   a_r10_ext_first_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (take && idx == ADR_LO && octet != own_ext[7:0]) |=> !ea_ok);

endmodule

// File: rtl/mff_decide.sv
module mff_decide (
   input  logic clk,
   input  logic rst_n,
   input  logic sof,
   input  logic eof_take,
   input  logic fcs_ok,
   input  logic filt_en,
   input  logic filt_pass,
   output logic dec_valid,
   output logic accept
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         accept    <= 1'b0;
      end else if (sof) begin
         dec_valid <= 1'b0;
         accept    <= 1'b0;
      end else if (eof_take) begin
         dec_valid <= 1'b1;
         accept    <= fcs_ok & (~filt_en | filt_pass);
      end
   end

   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (!dec_valid && !accept));

   a_r3_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_take && !sof) |=> dec_valid);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !sof) |=> (dec_valid && $stable(accept)));

   a_r4_bad_fcs: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_take && !fcs_ok) |=> !accept);

   a_r5_unfiltered: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_take && !filt_en && fcs_ok) |=> accept);

   a_r3_no_accept_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !accept);

endmodule

// File: rtl/mac_frame_filter.sv
module mac_frame_filter
   import mff_pkg::*;
#(
   parameter int PAN_W      = 16,
   parameter int SADDR_W    = 16,
   parameter int EADDR_W    = 64,
   parameter bit STREAM_CMP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frm_start,
   input  logic                 frm_end,
   input  logic                 fcs_ok,
   input  logic                 oct_valid,
   input  logic [7:0]           oct_data,
   input  logic                 filt_en,
   input  logic [6:0]           type_allow,
   input  logic [PAN_W-1:0]     own_pan,
   input  logic [SADDR_W-1:0]   own_short,
   input  logic [EADDR_W-1:0]   own_ext,
   output logic                 dec_valid,
   output logic                 accept
);

   localparam int PAN_B     = PAN_W / OCT_W;
   localparam int LEN_SHORT = FC_SEQ_LEN + PAN_B + SADDR_W / OCT_W;
   localparam int LEN_EXT   = FC_SEQ_LEN + PAN_B + EADDR_W / OCT_W;
   localparam int CNT_W     = $clog2(LEN_EXT + 1);

   localparam logic [CNT_W-1:0] NEED_NONE  = CNT_W'(FC_SEQ_LEN);
   localparam logic [CNT_W-1:0] NEED_SHORT = CNT_W'(LEN_SHORT);
   localparam logic [CNT_W-1:0] NEED_EXT   = CNT_W'(LEN_EXT);

   if ((PAN_W % OCT_W) != 0 || (SADDR_W % OCT_W) != 0 || (EADDR_W % OCT_W) != 0) begin : g_bad_width
      $error("mac_frame_filter: address widths must be whole octets");
   end
   if (SADDR_W > EADDR_W || PAN_W < OCT_W) begin : g_bad_order
      $error("mac_frame_filter: short address wider than extended, or empty PAN");
   end

   logic                take, eof_take;
   logic [CNT_W-1:0]    cnt;
   logic [FTYPE_W-1:0]  ftype;
   dst_mode_e           dmode;
   logic                pan_ok, sa_ok, ea_ok;
   logic                type_ok, hdr_ok, addr_ok, filt_pass;

   mff_hdr_parse #(.CNT_W(CNT_W)) u_parse (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof      (frm_start),
      .eof      (frm_end),
      .oct_v    (oct_valid),
      .octet    (oct_data),
      .take     (take),
      .eof_take (eof_take),
      .cnt      (cnt),
      .ftype    (ftype),
      .dmode    (dmode)
   );

   mff_addr_match #(
      .PAN_W      (PAN_W),
      .SADDR_W    (SADDR_W),
      .EADDR_W    (EADDR_W),
      .CNT_W      (CNT_W),
      .STREAM_CMP (STREAM_CMP)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (frm_start),
      .take      (take),
      .idx       (cnt),
      .octet     (oct_data),
      .own_pan   (own_pan),
      .own_short (own_short),
      .own_ext   (own_ext),
      .pan_ok    (pan_ok),
      .sa_ok     (sa_ok),
      .ea_ok     (ea_ok)
   );

   assign type_ok = type_allow[allow_index(ftype)];

   always_comb begin
      unique case (dmode)
         DM_NONE:  begin hdr_ok = (cnt >= NEED_NONE);  addr_ok = 1'b1;            end
         DM_SHORT: begin hdr_ok = (cnt >= NEED_SHORT); addr_ok = pan_ok & sa_ok;  end
         DM_EXT:   begin hdr_ok = (cnt >= NEED_EXT);   addr_ok = pan_ok & ea_ok;  end
         default:  begin hdr_ok = 1'b0;                addr_ok = 1'b0;            end
      endcase
   end

   assign filt_pass = type_ok & hdr_ok & addr_ok;

   mff_decide u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (frm_start),
      .eof_take  (eof_take),
      .fcs_ok    (fcs_ok),
      .filt_en   (filt_en),
      .filt_pass (filt_pass),
      .dec_valid (dec_valid),
      .accept    (accept)
   );

   // R11: a frame shorter than frame control plus sequence never passes
   a_r11_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_take && filt_en && cnt < NEED_NONE) |=> !accept);

   // R6: a disallowed type never passes when filtering
   a_r6_type_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_take && filt_en && !type_allow[allow_index(ftype)]) |=> !accept);

   // R7: reserved destination mode never passes when filtering
   a_r7_rsvd_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_take && filt_en && dmode == DM_RSVD) |=> !accept);

endmodule

// File: tb/tb_mac_frame_filter.sv
`timescale 1ns/1ps
module tb_mac_frame_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_start = 1'b0, frm_end = 1'b0, fcs_ok = 1'b0;
   logic        oct_valid = 1'b0;
   logic [7:0]  oct_data = 8'h00;
   logic        filt_en = 1'b0;
   logic [6:0]  type_allow = 7'h00;
   logic [15:0] own_pan   = 16'hCAFE;
   logic [15:0] own_short = 16'h1234;
   logic [63:0] own_ext   = 64'h0011_2233_4455_6677;
   logic        dec_valid, accept;

   int    n_run = 0, n_fail = 0;
   string cur_req = "R1";
   bit    cmp_on = 1'b0, done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   mac_frame_filter dut (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
      .fcs_ok(fcs_ok), .oct_valid(oct_valid), .oct_data(oct_data),
      .filt_en(filt_en), .type_allow(type_allow), .own_pan(own_pan),
      .own_short(own_short), .own_ext(own_ext),
      .dec_valid(dec_valid), .accept(accept)
   );

   // ---------------- behavioural reference model ----------------
   logic       m_valid = 1'b0, m_acc = 1'b0, m_in = 1'b0;
   logic [7:0] mq[$];

   function automatic logic model_decide(input logic fcs);
      logic [2:0]  t;
      logic [1:0]  dm;
      logic [15:0] pan, sa;
      logic [63:0] ea;
      int          bi;
      if (!fcs)               return 1'b0;
      if (!filt_en)           return 1'b1;
      if (mq.size() < 3)      return 1'b0;
      t  = mq[0][2:0];
      bi = (t > 3'd5) ? 6 : int'(t);
      if (!type_allow[bi])    return 1'b0;
      dm = mq[1][3:2];
      if (dm == 2'd0)         return 1'b1;
      if (dm == 2'd1)         return 1'b0;
      if (dm == 2'd2) begin
         if (mq.size() < 7)   return 1'b0;
         pan = {mq[4], mq[3]};
         sa  = {mq[6], mq[5]};
         return (pan == own_pan || pan == 16'hFFFF) && (sa == own_short || sa == 16'hFFFF);
      end
      if (mq.size() < 13)     return 1'b0;
      pan = {mq[4], mq[3]};
      ea  = '0;
      for (int k = 0; k < 8; k++) ea[k*8 +: 8] = mq[5+k];
      return (pan == own_pan || pan == 16'hFFFF) && (ea == own_ext);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 1'b0; m_acc = 1'b0; m_in = 1'b0; mq.delete();
      end else if (frm_start) begin
         m_in = 1'b1; m_valid = 1'b0; m_acc = 1'b0; mq.delete();
      end else begin
         if (m_in && oct_valid) mq.push_back(oct_data);
         if (m_in && frm_end) begin
            m_acc   = model_decide(fcs_ok);
            m_valid = 1'b1;
            m_in    = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         n_run++;
         if (dec_valid !== m_valid || accept !== m_acc) begin
            n_fail++;
            $display("FAIL %s model compare: valid=%b accept=%b expected valid=%b accept=%b",
                     cur_req, dec_valid, accept, m_valid, m_acc);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input logic got, input logic exp, input string req, input string what);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic send(input logic [7:0] fr[$], input logic fcs, input logic exp, input string req);
      cur_req = req;
      @(negedge clk) frm_start = 1'b1;
      @(negedge clk) frm_start = 1'b0;
      foreach (fr[i]) begin
         oct_valid = 1'b1;
         oct_data  = fr[i];
         @(negedge clk);
      end
      oct_valid = 1'b0;
      frm_end   = 1'b1;
      fcs_ok    = fcs;
      @(negedge clk);
      frm_end = 1'b0;
      fcs_ok  = 1'b0;
      chk(dec_valid, 1'b1, req, "decision valid after end (R3)");
      chk(accept, exp, req, "accept");
      @(negedge clk);
      chk(accept, exp, req, "accept held (R3)");
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R3 watchdog: got hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [7:0] fr[$];

      repeat (3) @(negedge clk);
      chk(dec_valid, 1'b0, "R1", "dec_valid in reset");
      chk(accept,    1'b0, "R1", "accept in reset");
      rst_n = 1'b1;
      // R12: octets and an end with no open frame after reset
      oct_valid = 1'b1; oct_data = 8'h41;
      @(negedge clk);
      oct_valid = 1'b0; frm_end = 1'b1; fcs_ok = 1'b1;
      @(negedge clk);
      frm_end = 1'b0; fcs_ok = 1'b0;
      @(negedge clk);
      chk(dec_valid, 1'b0, "R12", "no decision from stray end after reset");
      chk(accept,    1'b0, "R1",  "accept still clear");
      cmp_on = 1'b1;

      // R5: filter off, any content with good FCS accepted
      filt_en = 1'b0; type_allow = 7'h00;
      fr = '{8'h05};
      send(fr, 1'b1, 1'b1, "R5");
      send(fr, 1'b0, 1'b0, "R4");

      // Filtering on, short destination matching
      filt_en = 1'b1; type_allow = 7'h7F;
      fr = '{8'h41, 8'h08, 8'h11, 8'hFE, 8'hCA, 8'h34, 8'h12, 8'hAA, 8'hBB};
      send(fr, 1'b1, 1'b1, "R9");
      send(fr, 1'b0, 1'b0, "R4");

      // R6: data type disallowed
      type_allow = 7'h7F & ~7'h02;
      send(fr, 1'b1, 1'b0, "R6");
      type_allow = 7'h7F;

      // R6: types 6 and 7 share bit 6
      fr = '{8'h07, 8'h00, 8'h01};
      send(fr, 1'b1, 1'b1, "R6");
      type_allow = 7'h3F;
      fr = '{8'h06, 8'h00, 8'h01};
      send(fr, 1'b1, 1'b0, "R6");
      type_allow = 7'h7F;

      // ack, no destination
      fr = '{8'h02, 8'h00, 8'h05};
      send(fr, 1'b1, 1'b1, "R7");

      // R8/R9 broadcasts
      fr = '{8'h41, 8'h08, 8'h12, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      send(fr, 1'b1, 1'b1, "R8");
      // R8 PAN mismatch
      fr = '{8'h41, 8'h08, 8'h13, 8'hFE, 8'hCB, 8'h34, 8'h12};
      send(fr, 1'b1, 1'b0, "R8");
      // R9 short mismatch in high octet
      fr = '{8'h41, 8'h08, 8'h14, 8'hFE, 8'hCA, 8'h34, 8'h13};
      send(fr, 1'b1, 1'b0, "R9");

      // R10 extended
      fr = '{8'h41, 8'h0C, 8'h15, 8'hFE, 8'hCA,
             8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h00, 8'h99};
      send(fr, 1'b1, 1'b1, "R10");
      fr = '{8'h41, 8'h0C, 8'h16, 8'hFE, 8'hCA,
             8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h01};
      send(fr, 1'b1, 1'b0, "R10");
      fr = '{8'h41, 8'h0C, 8'h17, 8'hFE, 8'hCA,
             8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      send(fr, 1'b1, 1'b0, "R10");

      // R7 reserved destination mode
      fr = '{8'h41, 8'h04, 8'h18, 8'hFE, 8'hCA, 8'h34, 8'h12};
      send(fr, 1'b1, 1'b0, "R7");

      // R11 truncated header, then same frame with filter off
      fr = '{8'h41, 8'h08, 8'h19, 8'hFE, 8'hCA};
      send(fr, 1'b1, 1'b0, "R11");
      fr = '{8'h41, 8'h0C, 8'h1A, 8'hFE, 8'hCA, 8'h77, 8'h66, 8'h55};
      send(fr, 1'b1, 1'b0, "R11");
      filt_en = 1'b0;
      send(fr, 1'b1, 1'b1, "R5");
      filt_en = 1'b1;

      // R12 / R3: accepted frame, then stray octets and end outside a frame
      fr = '{8'h41, 8'h08, 8'h1B, 8'hFE, 8'hCA, 8'h34, 8'h12};
      send(fr, 1'b1, 1'b1, "R3");
      cur_req = "R12";
      oct_valid = 1'b1; oct_data = 8'h00;
      @(negedge clk);
      oct_valid = 1'b0; frm_end = 1'b1; fcs_ok = 1'b0;
      @(negedge clk);
      frm_end = 1'b0;
      @(negedge clk);
      chk(dec_valid, 1'b1, "R12", "valid kept after stray end");
      chk(accept,    1'b1, "R12", "accept kept after stray end");

      // R2: start clears; octet in start cycle ignored
      cur_req = "R2";
      frm_start = 1'b1; oct_valid = 1'b1; oct_data = 8'h00;
      @(negedge clk);
      frm_start = 1'b0; oct_valid = 1'b0;
      chk(dec_valid, 1'b0, "R2", "valid cleared by start");
      chk(accept,    1'b0, "R2", "accept cleared by start");
      foreach (fr[i]) begin
         oct_valid = 1'b1; oct_data = fr[i];
         @(negedge clk);
      end
      oct_valid = 1'b0; frm_end = 1'b1; fcs_ok = 1'b1;
      @(negedge clk);
      frm_end = 1'b0; fcs_ok = 1'b0;
      chk(accept, 1'b1, "R12", "octet in start cycle not counted");

      // R2: start and end together, start wins
      frm_start = 1'b1; frm_end = 1'b1; fcs_ok = 1'b1;
      @(negedge clk);
      frm_start = 1'b0; frm_end = 1'b0; fcs_ok = 1'b0;
      chk(dec_valid, 1'b0, "R2", "start wins over end");
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule